// File: doc/BRIEF.md
# Single-Beat External Bus Master

This block performs one read or one write at a time on a shared external bus that several masters reach through an arbiter. An internal client presents an address, a direction flag, a size code and, for writes, the data to write. The controller then asks the arbiter for the bus and waits for a grant. It waits further while any other master still holds the busy line. It then claims the bus with its own busy line and marks the address phase with a one-cycle start strobe. For writes it leaves one dead cycle before driving the data bus. It finishes when the addressed slave acknowledges. Read data and a one-cycle done pulse then return to the client.

All bus control lines are active-low and come straight from flops clocked on the rising edge. The outgoing data bus has its own output enable, so the pad ring can tri-state it. Only one transaction is in flight at a time. The client may only start a new one while the ready output is high.

Top module: `xbus_single_master`

## Requirements
- R1: `usr_ready` is high exactly when the controller is idle. `usr_valid` is accepted only on a rising edge where `usr_ready` is high. A request presented while busy has no effect on the bus outputs or on the transaction in progress.
- R2: In the cycle after a request is accepted, `bus_req_n` goes low. It stays low until a rising edge where `bus_grant_n` is low and `bus_busy_in_n` is high.
- R3: The cycle after that edge, `bus_busy_out_n` goes low and `bus_req_n` returns high. While `bus_busy_in_n` is low, the grant is not taken up and the request stays asserted.
- R4: `xfer_start_n` is low for exactly one cycle, the cycle after the bus is claimed. `bus_busy_out_n` is low in that cycle.
- R5: `bus_addr`, `bus_write` (1 = write, 0 = read) and `bus_size` carry the accepted request's values. They stay unchanged while `bus_busy_out_n` is low.
- R6: On a write, `bus_wdata_oe` is low in the start cycle and in the dead cycle after it. It is high from the second cycle after the start strobe until the acknowledge is sampled, with `bus_wdata` equal to the write data. It is never high on a read.
- R7: A low `xfer_ack_n` in the start-strobe cycle, or in a write's dead cycle, is ignored and does not end the transaction.
- R8: On a read, `bus_rdata` is captured at the rising edge where `xfer_ack_n` is sampled low. That value appears on `usr_rdata` together with `usr_done`.
- R9: The cycle after the acknowledge is sampled, `bus_busy_out_n` is high, `bus_wdata_oe` is low and `usr_done` is high for one cycle. `usr_ready` is high the cycle after that.
- R10: While `rst_n` is low, `usr_ready` is high and `bus_req_n`, `bus_busy_out_n` and `xfer_start_n` are high. `bus_wdata_oe` and `usr_done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| usr_valid | input | 1 | Client request strobe |
| usr_ready | output | 1 | Controller idle; a request will be taken |
| usr_write | input | 1 | 1 = write, 0 = read |
| usr_addr | input | AW (32) | Request address |
| usr_size | input | SW (2) | Transfer size code, passed through |
| usr_wdata | input | DW (32) | Write data |
| usr_done | output | 1 | One-cycle completion pulse |
| usr_rdata | output | DW (32) | Read data, valid with `usr_done` on reads |
| bus_req_n | output | 1 | Bus request to the arbiter, active low |
| bus_grant_n | input | 1 | Bus grant from the arbiter, active low |
| bus_busy_in_n | input | 1 | Busy line as driven by other masters, active low |
| bus_busy_out_n | output | 1 | This master's busy line, active low |
| xfer_start_n | output | 1 | Transfer start strobe, active low |
| xfer_ack_n | input | 1 | Transfer acknowledge from the slave, active low |
| bus_addr | output | AW (32) | Address to the bus |
| bus_write | output | 1 | Direction attribute, 1 = write |
| bus_size | output | SW (2) | Size attribute |
| bus_wdata | output | DW (32) | Outgoing data |
| bus_wdata_oe | output | 1 | Output enable for `bus_wdata` |
| bus_rdata | input | DW (32) | Incoming data |

## Verification
Each output is due a fixed number of edges after the input that causes it. The request appears one edge after acceptance. Busy follows one edge after a usable grant and the start strobe one edge after that. Write data is enabled two edges after the start strobe. Done follows one edge after the sampled acknowledge, and ready one edge later. The bench keeps a behavioural model that steps on the same rising edge as the design from the same inputs. It compares every output at the following falling edge, so each result is checked in the exact cycle it is due and never early or late. Scenarios cover grant delay, a grant offered while another master is busy, acknowledges placed in ignored cycles, and requests poked in while busy.

// File: rtl/xbm_pkg.sv
package xbm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_CLAIM = 3'd2,
    ST_ADDR  = 3'd3,
    ST_TURN  = 3'd4,
    ST_WDATA = 3'd5,
    ST_RWAIT = 3'd6,
    ST_DONE  = 3'd7
  } xbm_state_e;

  typedef struct packed {
    logic ready;
    logic br_n;
    logic bb_n;
    logic ts_n;
    logic oe;
    logic done;
  } xbm_ctl_t;

  function automatic xbm_ctl_t xbm_decode(input xbm_state_e s);
    xbm_ctl_t c;
    c.ready = 1'b0;
    c.br_n  = 1'b1;
    c.bb_n  = 1'b1;
    c.ts_n  = 1'b1;
    c.oe    = 1'b0;
    c.done  = 1'b0;
    case (s)
      ST_IDLE:  c.ready = 1'b1;
      ST_REQ:   c.br_n  = 1'b0;
      ST_CLAIM: c.bb_n  = 1'b0;
      ST_ADDR: begin
        c.bb_n = 1'b0;
        c.ts_n = 1'b0;
      end
      ST_TURN:  c.bb_n  = 1'b0;
      ST_WDATA: begin
        c.bb_n = 1'b0;
        c.oe   = 1'b1;
      end
      ST_RWAIT: c.bb_n  = 1'b0;
      ST_DONE:  c.done  = 1'b1;
      default:  c.ready = 1'b0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/xbm_req_hold.sv
module xbm_req_hold #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          in_write,
  input  logic [AW-1:0] in_addr,
  input  logic [SW-1:0] in_size,
  input  logic [DW-1:0] in_wdata,
  output logic          out_write,
  output logic [AW-1:0] out_addr,
  output logic [SW-1:0] out_size,
  output logic [DW-1:0] out_wdata
);

  logic          write_d;
  logic [AW-1:0] addr_d;
  logic [SW-1:0] size_d;
  logic [DW-1:0] wdata_d;

  always_comb begin
    write_d = out_write;
    addr_d  = out_addr;
    size_d  = out_size;
    wdata_d = out_wdata;
    if (load) begin
      write_d = in_write;
      addr_d  = in_addr;
      size_d  = in_size;
      wdata_d = in_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_write <= 1'b0;
      out_addr  <= '0;
      out_size  <= '0;
      out_wdata <= '0;
    end else begin
      out_write <= write_d;
      out_addr  <= addr_d;
      out_size  <= size_d;
      out_wdata <= wdata_d;
    end
  end

endmodule

// File: rtl/xbm_seq.sv
module xbm_seq
  import xbm_pkg::*;
#(
  parameter int TURN_CYCLES = 1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     usr_valid,
  input  logic     is_write,
  input  logic     grant_n,
  input  logic     busy_in_n,
  input  logic     ack_n,
  output logic     accept,
  output logic     ack_take,
  output xbm_ctl_t ctl
);

  localparam int TCW = (TURN_CYCLES < 2) ? 1 : $clog2(TURN_CYCLES);
  localparam logic [TCW-1:0] TURN_LAST = TCW'(TURN_CYCLES - 1);

  xbm_state_e     st_q, st_d;
  logic [TCW-1:0] turn_q, turn_d;
  xbm_ctl_t       ctl_d;

  assign accept   = (st_q == ST_IDLE) && usr_valid;
  assign ack_take = ((st_q == ST_WDATA) || (st_q == ST_RWAIT)) && !ack_n;

  always_comb begin
    st_d   = st_q;
    turn_d = turn_q;
    case (st_q)
      ST_IDLE:  if (usr_valid) st_d = ST_REQ;
      ST_REQ:   if (!grant_n && busy_in_n) st_d = ST_CLAIM;
      ST_CLAIM: st_d = ST_ADDR;
      ST_ADDR: begin
        turn_d = '0;
        st_d   = is_write ? ST_TURN : ST_RWAIT;
      end
      ST_TURN: begin
        if (turn_q == TURN_LAST) st_d = ST_WDATA;
        else turn_d = turn_q + 1'b1;
      end
      ST_WDATA: if (!ack_n) st_d = ST_DONE;
      ST_RWAIT: if (!ack_n) st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
    ctl_d = xbm_decode(st_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      turn_q <= '0;
      ctl    <= xbm_decode(ST_IDLE);
    end else begin
      st_q   <= st_d;
      turn_q <= turn_d;
      ctl    <= ctl_d;
    end
  end

endmodule

// File: rtl/xbm_rd_cap.sv
module xbm_rd_cap #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [DW-1:0] bus_data,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] rdata_d;

  always_comb begin
    rdata_d = rdata;
    if (take) rdata_d = bus_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_d;
  end

endmodule

// File: rtl/xbus_single_master.sv
module xbus_single_master
  import xbm_pkg::*;
#(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int SW          = 2,
  parameter int TURN_CYCLES = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          usr_valid,
  output logic          usr_ready,
  input  logic          usr_write,
  input  logic [AW-1:0] usr_addr,
  input  logic [SW-1:0] usr_size,
  input  logic [DW-1:0] usr_wdata,
  output logic          usr_done,
  output logic [DW-1:0] usr_rdata,
  output logic          bus_req_n,
  input  logic          bus_grant_n,
  input  logic          bus_busy_in_n,
  output logic          bus_busy_out_n,
  output logic          xfer_start_n,
  input  logic          xfer_ack_n,
  output logic [AW-1:0] bus_addr,
  output logic          bus_write,
  output logic [SW-1:0] bus_size,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_wdata_oe,
  input  logic [DW-1:0] bus_rdata
);

  logic     accept;
  logic     ack_take;
  logic     rd_take;
  xbm_ctl_t ctl;

  xbm_req_hold #(.AW(AW), .DW(DW), .SW(SW)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .in_write  (usr_write),
    .in_addr   (usr_addr),
    .in_size   (usr_size),
    .in_wdata  (usr_wdata),
    .out_write (bus_write),
    .out_addr  (bus_addr),
    .out_size  (bus_size),
    .out_wdata (bus_wdata)
  );

  xbm_seq #(.TURN_CYCLES(TURN_CYCLES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .usr_valid (usr_valid),
    .is_write  (bus_write),
    .grant_n   (bus_grant_n),
    .busy_in_n (bus_busy_in_n),
    .ack_n     (xfer_ack_n),
    .accept    (accept),
    .ack_take  (ack_take),
    .ctl       (ctl)
  );

  assign rd_take = ack_take && !bus_write;

  xbm_rd_cap #(.DW(DW)) u_rcap (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (rd_take),
    .bus_data (bus_rdata),
    .rdata    (usr_rdata)
  );

  assign usr_ready      = ctl.ready;
  assign usr_done       = ctl.done;
  assign bus_req_n      = ctl.br_n;
  assign bus_busy_out_n = ctl.bb_n;
  assign xfer_start_n   = ctl.ts_n;
  assign bus_wdata_oe   = ctl.oe;

endmodule

// File: rtl/xbm_checker.sv
module xbm_checker (
  input logic clk,
  input logic rst_n,
  input logic usr_ready,
  input logic usr_done,
  input logic bus_req_n,
  input logic bus_grant_n,
  input logic bus_busy_in_n,
  input logic bus_busy_out_n,
  input logic xfer_start_n,
  input logic xfer_ack_n,
  input logic bus_wdata_oe,
  input logic bus_write,
  input logic [31:0] bus_addr
);

  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    usr_ready |-> (bus_req_n && bus_busy_out_n && xfer_start_n));

  p_req_or_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_req_n && !bus_busy_out_n));

  p_claim_on_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_busy_out_n) |-> $past(!bus_grant_n && bus_busy_in_n));

  p_start_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_start_n |=> xfer_start_n);

  p_start_under_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_start_n |-> (!bus_busy_out_n && $past(!bus_busy_out_n)));

  p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_busy_out_n && $past(!bus_busy_out_n)) |-> ($stable(bus_addr) && $stable(bus_write)));

  p_dead_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wdata_oe) |-> ($past(xfer_start_n) && bus_write));

  p_no_oe_in_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_start_n |-> !bus_wdata_oe);

  p_done_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    usr_done |-> ($past(!xfer_ack_n) && bus_busy_out_n && !bus_wdata_oe));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    usr_done |=> (!usr_done && usr_ready));

endmodule

bind xbus_single_master xbm_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .usr_ready      (usr_ready),
  .usr_done       (usr_done),
  .bus_req_n      (bus_req_n),
  .bus_grant_n    (bus_grant_n),
  .bus_busy_in_n  (bus_busy_in_n),
  .bus_busy_out_n (bus_busy_out_n),
  .xfer_start_n   (xfer_start_n),
  .xfer_ack_n     (xfer_ack_n),
  .bus_wdata_oe   (bus_wdata_oe),
  .bus_write      (bus_write),
  .bus_addr       (bus_addr[31:0])
);

// File: tb/xbus_single_master_tb.sv
module xbus_single_master_tb;

  logic        clk;
  logic        rst_n;
  logic        usr_valid;
  logic        usr_ready;
  logic        usr_write;
  logic [31:0] usr_addr;
  logic [1:0]  usr_size;
  logic [31:0] usr_wdata;
  logic        usr_done;
  logic [31:0] usr_rdata;
  logic        bus_req_n;
  logic        bus_grant_n;
  logic        bus_busy_in_n;
  logic        bus_busy_out_n;
  logic        xfer_start_n;
  logic        xfer_ack_n;
  logic [31:0] bus_addr;
  logic        bus_write;
  logic [1:0]  bus_size;
  logic [31:0] bus_wdata;
  logic        bus_wdata_oe;
  logic [31:0] bus_rdata;

  int n_chk;
  int n_bad;
  int cyc;
  bit finished;

  xbus_single_master u_dut (
    .clk(clk), .rst_n(rst_n), .usr_valid(usr_valid), .usr_ready(usr_ready),
    .usr_write(usr_write), .usr_addr(usr_addr), .usr_size(usr_size),
    .usr_wdata(usr_wdata), .usr_done(usr_done), .usr_rdata(usr_rdata),
    .bus_req_n(bus_req_n), .bus_grant_n(bus_grant_n),
    .bus_busy_in_n(bus_busy_in_n), .bus_busy_out_n(bus_busy_out_n),
    .xfer_start_n(xfer_start_n), .xfer_ack_n(xfer_ack_n),
    .bus_addr(bus_addr), .bus_write(bus_write), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Behavioural reference: phase of the transaction as seen at the pins.
  // 0 idle, 1 requesting, 2 claimed, 3 start, 4 dead, 5 write data, 6 read wait, 7 done
  int          m_ph;
  bit          m_wr;
  logic [31:0] m_addr;
  logic [1:0]  m_size;
  logic [31:0] m_wd;
  logic [31:0] m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0;
    end else begin
      case (m_ph)
        0: if (usr_valid) begin
             m_ph = 1; m_wr = usr_write; m_addr = usr_addr;
             m_size = usr_size; m_wd = usr_wdata;
           end
        1: if (!bus_grant_n && bus_busy_in_n) m_ph = 2;
        2: m_ph = 3;
        3: m_ph = m_wr ? 4 : 6;
        4: m_ph = 5;
        5: if (!xfer_ack_n) m_ph = 7;
        6: if (!xfer_ack_n) begin m_ph = 7; m_rd = bus_rdata; end
        default: m_ph = 0;
      endcase
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      cyc++;
      if (!rst_n) begin
        chk("R10", "ready", {31'd0, usr_ready}, 32'd1);
        chk("R10", "req_n", {31'd0, bus_req_n}, 32'd1);
        chk("R10", "busy_n", {31'd0, bus_busy_out_n}, 32'd1);
        chk("R10", "start_n", {31'd0, xfer_start_n}, 32'd1);
        chk("R10", "oe", {31'd0, bus_wdata_oe}, 32'd0);
        chk("R10", "done", {31'd0, usr_done}, 32'd0);
      end else begin
        chk("R1", "ready", {31'd0, usr_ready}, {31'd0, m_ph == 0});
        chk("R2", "req_n", {31'd0, bus_req_n}, {31'd0, m_ph != 1});
        chk("R3", "busy_n", {31'd0, bus_busy_out_n}, {31'd0, !(m_ph >= 2 && m_ph <= 6)});
        chk("R4", "start_n", {31'd0, xfer_start_n}, {31'd0, m_ph != 3});
        chk("R6", "oe", {31'd0, bus_wdata_oe}, {31'd0, m_ph == 5});
        chk("R9", "done", {31'd0, usr_done}, {31'd0, m_ph == 7});
        if (m_ph >= 3 && m_ph <= 6) begin
          chk("R5", "addr", bus_addr, m_addr);
          chk("R5", "write", {31'd0, bus_write}, {31'd0, m_wr});
          chk("R5", "size", {30'd0, bus_size}, {30'd0, m_size});
        end
        if (m_ph == 5) chk("R6", "wdata", bus_wdata, m_wd);
        if (m_ph == 7 && !m_wr) chk("R8", "rdata", usr_rdata, m_rd);
      end
    end
  end

  task automatic run_txn(input bit wr, input logic [31:0] a, input logic [31:0] d,
                         input logic [1:0] sz, input int gdly, input int bdly,
                         input int tdly, input bit early, input bit poke,
                         input logic [31:0] rdv);
    @(negedge clk);
    usr_write = wr; usr_addr = a; usr_wdata = d; usr_size = sz; usr_valid = 1'b1;
    @(negedge clk);
    usr_valid = 1'b0;
    if (poke) begin
      // R1: request while busy must be ignored
      usr_valid = 1'b1; usr_addr = ~a; usr_write = ~wr;
    end
    repeat (gdly) @(negedge clk);
    usr_valid = 1'b0;
    bus_grant_n = 1'b0;
    if (bdly > 0) bus_busy_in_n = 1'b0;
    for (int i = 0; i < bdly; i++) @(negedge clk);
    bus_busy_in_n = 1'b1;
    while (bus_busy_out_n) @(negedge clk);
    bus_grant_n = 1'b1;
    while (xfer_start_n) @(negedge clk);
    if (early) begin
      xfer_ack_n = 1'b0;
      @(negedge clk);
      if (wr) @(negedge clk);
      xfer_ack_n = 1'b1;
      // R7: early acknowledge must not end the transfer
      chk("R7", "done after early ack", {31'd0, usr_done}, 32'd0);
      chk("R7", "busy after early ack", {31'd0, bus_busy_out_n}, 32'd0);
    end else begin
      @(negedge clk);
    end
    if (wr) while (!bus_wdata_oe) @(negedge clk);
    repeat (tdly) @(negedge clk);
    bus_rdata = rdv; xfer_ack_n = 1'b0;
    @(negedge clk);
    xfer_ack_n = 1'b1; bus_rdata = 32'hBAD0_0BAD;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 20000 && !finished) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected completion");
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; cyc = 0; finished = 1'b0;
    rst_n = 1'b0; usr_valid = 1'b0; usr_write = 1'b0; usr_addr = '0;
    usr_size = '0; usr_wdata = '0; bus_grant_n = 1'b1; bus_busy_in_n = 1'b1;
    xfer_ack_n = 1'b1; bus_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R8 read, grant at once, ack right after start
    run_txn(1'b0, 32'h1000_0040, 32'h0, 2'd2, 0, 0, 0, 1'b0, 1'b0, 32'hCAFE_F00D);
    // R6 write with a delayed grant and slow ack
    run_txn(1'b1, 32'h2000_0004, 32'h1234_5678, 2'd1, 3, 0, 2, 1'b0, 1'b0, 32'h0);
    // R3 grant while another master holds busy
    run_txn(1'b0, 32'h3000_0100, 32'h0, 2'd0, 1, 4, 1, 1'b0, 1'b0, 32'h0BAD_BEEF);
    // R7 early ack on a read
    run_txn(1'b0, 32'h4000_0008, 32'h0, 2'd3, 0, 0, 0, 1'b1, 1'b0, 32'h5555_AAAA);
    // R7 early ack on a write (start and dead cycle)
    run_txn(1'b1, 32'h5000_000C, 32'hA5A5_5A5A, 2'd2, 0, 0, 0, 1'b1, 1'b0, 32'h0);
    // R1 poke while busy, read and write
    run_txn(1'b0, 32'h6000_0010, 32'h0, 2'd1, 2, 1, 3, 1'b0, 1'b1, 32'h7777_1111);
    run_txn(1'b1, 32'h7000_0020, 32'hDEAD_C0DE, 2'd0, 2, 0, 0, 1'b0, 1'b1, 32'h0);
    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule